// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Mapping

This block steps through microprograms held in an internal control memory and drives the control lines of a datapath from the current microinstruction. Each 32-bit microinstruction word has three fields. Bits [31:30] hold a 2-bit condition code, bits [29:24] hold a 6-bit branch target, and bits [23:0] hold 24 control bits. The datapath itself sits outside this block. So does the main-memory fetch that supplies opcodes.

A micro-program counter (micro-PC) selects the current word. When an instruction-load strobe arrives, a 16-entry mapping table turns the 4-bit opcode into the start address of that instruction's microprogram. Otherwise the condition code and a status flag decide the next address. The next address is either the following word, the branch target, or address 0, where the fetch routine lives.

The control memory and the mapping table each have a write port. The surrounding system fills both before the sequencer is used, usually while reset is held. The control memory is read synchronously. The sequencer addresses it with the next address, so the word for a new micro-PC value appears in the same cycle as that value, and the sequencer issues one microinstruction every cycle.

Top module: `uSeqTop`

## Requirements
- R1: When `opLoad` is 1 in a cycle with `ctrlValid` 1, after the next clock edge `uPc` equals the mapping-table entry indexed by `opcode`.
- R2: Writing `mapWrAddr` into table entry `mapWrIdx` with `mapWrEn` changes the start address used by every later `opLoad` of that opcode.
- R3: While `ctrlValid` is 1, `ctrlOut` equals bits [23:0] of the control-memory word at address `uPc`. A 1 bit drives its line active and a 0 bit leaves it inactive. The memory word must have been written through `cmWrEn`/`cmWrAddr`/`cmWrData` in an earlier cycle.
- R4: Condition code 01 (always), or condition code 10 with `statusFlag` equal to 1, loads `uPc` with bits [29:24] of the current word at the next edge.
- R5: Condition code 00, or condition code 10 with `statusFlag` equal to 0, loads `uPc` with `uPc`+1 at the next edge. Under code 00, `statusFlag` has no effect.
- R6: Condition code 11 ends the microprogram, and `uPc` becomes 0 at the next edge.
- R7: A sequential step from address 63 wraps to address 0.
- R8: `opLoad` takes priority over every condition code, including a taken branch and the end code.
- R9: While `rstN` is 0, `uPc` is 0, `ctrlValid` is 0 and `ctrlOut` is 0. At the first clock edge after release, `ctrlValid` becomes 1 with `uPc` 0 and `ctrlOut` showing word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmWrEn | input | 1 | Control-memory write strobe |
| cmWrAddr | input | 6 | Control-memory write address |
| cmWrData | input | 32 | Microinstruction word to write |
| mapWrEn | input | 1 | Mapping-table write strobe |
| mapWrIdx | input | 4 | Opcode whose table entry is written |
| mapWrAddr | input | 6 | Start address stored for that opcode |
| opLoad | input | 1 | Instruction-load event: jump to the mapped start address |
| opcode | input | 4 | Opcode of the loaded instruction |
| statusFlag | input | 1 | Datapath status tested by condition code 10 |
| ctrlOut | output | 24 | Control lines of the current microinstruction |
| ctrlValid | output | 1 | Current microinstruction is valid |
| uPc | output | 6 | Micro-program counter |

## Verification
The bench runs the fetch loop and follows the path both ways at the flag-tested branch. A design that ignored the flag, or inverted it, would land on address 28 where 40 is expected, or the reverse. It steps a microprogram through address 63, so a counter that saturated or failed to wrap would not come back to 0. It raises `opLoad` on a word that would branch and on a word that ends the microprogram, so a sequencer that let the condition code win would show the branch target or 0 instead of the mapped start. It also remaps an opcode during a run and asserts reset mid-program, which catches a stale mapping table, and a first word shown after reset before the memory read has completed.

// File: rtl/uSeqPkg.sv
package uSeqPkg;

  typedef enum logic [1:0] {
    COND_SEQ  = 2'b00,
    COND_JMP  = 2'b01,
    COND_FLAG = 2'b10,
    COND_END  = 2'b11
  } condCode_e;

  // strobes from the control part to the address datapath
  typedef struct packed {
    logic prime;     // first cycle after reset: fetch word 0
    logic takeMap;   // next address from the opcode map
    logic takeJump;  // next address from the word's target field
    logic takeEnd;   // next address is the fetch routine (0)
  } seqStrobes_t;

endpackage

// File: rtl/uSeqCtrl.sv
module uSeqCtrl
  import uSeqPkg::*;
(
  input  logic        validQ,
  input  logic        opLoad,
  input  logic [1:0]  condBits,
  input  logic        statusFlag,
  output seqStrobes_t strobes
);

  condCode_e cond;
  assign cond = condCode_e'(condBits);

  always_comb begin
    strobes = '0;
    if (!validQ) begin
      strobes.prime = 1'b1;
    end else if (opLoad) begin
      strobes.takeMap = 1'b1;
    end else begin
      unique case (cond)
        COND_JMP:  strobes.takeJump = 1'b1;
        COND_FLAG: strobes.takeJump = statusFlag;
        COND_END:  strobes.takeEnd  = 1'b1;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/uSeqPath.sv
module uSeqPath
  import uSeqPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 32,
  parameter int OP_W   = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqStrobes_t                   strobes,
  input  logic                          cmWrEn,
  input  logic [ADDR_W-1:0]             cmWrAddr,
  input  logic [WORD_W-1:0]             cmWrData,
  input  logic                          mapWrEn,
  input  logic [OP_W-1:0]               mapWrIdx,
  input  logic [ADDR_W-1:0]             mapWrAddr,
  input  logic [OP_W-1:0]               opcode,
  output logic                          validQ,
  output logic [1:0]                    condBits,
  output logic [ADDR_W-1:0]             pcQ,
  output logic [WORD_W-1:0]             wordQ,
  output logic [WORD_W-2-ADDR_W-1:0]    ctrlOut
);

  localparam int COND_W = 2;
  localparam int CTRL_W = WORD_W - COND_W - ADDR_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int MAP_N  = 1 << OP_W;

  logic [WORD_W-1:0] cmem   [DEPTH];
  logic [ADDR_W-1:0] mapTab [MAP_N];
  logic [ADDR_W-1:0] nextPc;
  logic [ADDR_W-1:0] target;

  assign target   = wordQ[CTRL_W +: ADDR_W];
  assign condBits = wordQ[WORD_W-1 -: COND_W];

  always_comb begin
    if (strobes.prime || strobes.takeEnd) nextPc = '0;
    else if (strobes.takeMap)             nextPc = mapTab[opcode];
    else if (strobes.takeJump)            nextPc = target;
    else                                  nextPc = pcQ + ADDR_W'(1);
  end

  // opcode mapping table, one register per opcode
  for (genvar g = 0; g < MAP_N; g++) begin : gMap
    always_ff @(posedge clk) begin
      if (mapWrEn && (mapWrIdx == OP_W'(g))) mapTab[g] <= mapWrAddr;
    end
  end

  // control memory: synchronous read addressed by the next micro-PC
  always_ff @(posedge clk) begin
    if (cmWrEn) cmem[cmWrAddr] <= cmWrData;
    wordQ <= cmem[nextPc];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ    <= '0;
      validQ <= 1'b0;
    end else begin
      pcQ    <= nextPc;
      validQ <= 1'b1;
    end
  end

  assign ctrlOut = validQ ? wordQ[CTRL_W-1:0] : '0;

endmodule

// File: rtl/uSeqTop.sv
module uSeqTop
  import uSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmWrEn,
  input  logic [5:0]  cmWrAddr,
  input  logic [31:0] cmWrData,
  input  logic        mapWrEn,
  input  logic [3:0]  mapWrIdx,
  input  logic [5:0]  mapWrAddr,
  input  logic        opLoad,
  input  logic [3:0]  opcode,
  input  logic        statusFlag,
  output logic [23:0] ctrlOut,
  output logic        ctrlValid,
  output logic [5:0]  uPc
);

  localparam int ADDR_W = 6;
  localparam int WORD_W = 32;
  localparam int OP_W   = 4;

  seqStrobes_t       strobes;
  logic [1:0]        condBits;
  logic [WORD_W-1:0] curWord;

  uSeqCtrl ctrl_i (
    .validQ    (ctrlValid),
    .opLoad    (opLoad),
    .condBits  (condBits),
    .statusFlag(statusFlag),
    .strobes   (strobes)
  );

  uSeqPath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .OP_W(OP_W)) path_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cmWrEn   (cmWrEn),
    .cmWrAddr (cmWrAddr),
    .cmWrData (cmWrData),
    .mapWrEn  (mapWrEn),
    .mapWrIdx (mapWrIdx),
    .mapWrAddr(mapWrAddr),
    .opcode   (opcode),
    .validQ   (ctrlValid),
    .condBits (condBits),
    .pcQ      (uPc),
    .wordQ    (curWord),
    .ctrlOut  (ctrlOut)
  );

endmodule

// File: rtl/uSeqChecker.sv
module uSeqChecker (
  input logic        clk,
  input logic        rstN,
  input logic        opLoad,
  input logic        statusFlag,
  input logic        ctrlValid,
  input logic [5:0]  uPc,
  input logic [31:0] curWord
);

  logic [1:0] cc;
  assign cc = curWord[31:30];

  // R5: sequential step (wraps per R7)
  assert_seq_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlValid && !opLoad && (cc == 2'b00 || (cc == 2'b10 && !statusFlag)))
    |=> (uPc == $past(uPc) + 6'd1));

  // R4: taken branch uses the target field
  assert_branch_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlValid && !opLoad && (cc == 2'b01 || (cc == 2'b10 && statusFlag)))
    |=> (uPc == $past(curWord[29:24])));

  // R6: end code returns to fetch
  assert_end_to_fetch_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlValid && !opLoad && cc == 2'b11) |=> (uPc == 6'd0));

  // R9: the first valid cycle starts at address 0
  assert_start_at_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlValid) |-> (uPc == 6'd0));

  // R1: a load keeps the sequencer running
  assert_load_keeps_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlValid && opLoad) |=> ctrlValid);

endmodule

bind uSeqTop uSeqChecker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .opLoad    (opLoad),
  .statusFlag(statusFlag),
  .ctrlValid (ctrlValid),
  .uPc       (uPc),
  .curWord   (curWord)
);

// File: tb/uSeqTop_tb_top.sv
`timescale 1ns/1ps
module uSeqTop_tb_top;

  localparam int CLK_NS = 20;
  localparam int NVEC   = 28;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmWrEn = 1'b0;
  logic [5:0]  cmWrAddr = '0;
  logic [31:0] cmWrData = '0;
  logic        mapWrEn = 1'b0;
  logic [3:0]  mapWrIdx = '0;
  logic [5:0]  mapWrAddr = '0;
  logic        opLoad = 1'b0;
  logic [3:0]  opcode = '0;
  logic        statusFlag = 1'b0;
  logic [23:0] ctrlOut;
  logic        ctrlValid;
  logic [5:0]  uPc;

  int total = 0;
  int bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  uSeqTop dut_i (
    .clk(clk), .rstN(rstN),
    .cmWrEn(cmWrEn), .cmWrAddr(cmWrAddr), .cmWrData(cmWrData),
    .mapWrEn(mapWrEn), .mapWrIdx(mapWrIdx), .mapWrAddr(mapWrAddr),
    .opLoad(opLoad), .opcode(opcode), .statusFlag(statusFlag),
    .ctrlOut(ctrlOut), .ctrlValid(ctrlValid), .uPc(uPc)
  );

  // vector: {opLoad, opcode, statusFlag, expected uPc after the edge}
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 4'd0,  1'b0, 6'd0},   // first edge after reset: word 0 (R9)
    {1'b0, 4'd0,  1'b1, 6'd1},   // status ignored under code 00 (R5)
    {1'b0, 4'd0,  1'b0, 6'd2},
    {1'b0, 4'd0,  1'b0, 6'd2},   // always-branch spin (R4)
    {1'b1, 4'd3,  1'b0, 6'd26},  // map opcode 3 (R1)
    {1'b0, 4'd0,  1'b0, 6'd27},
    {1'b0, 4'd0,  1'b1, 6'd40},  // flag branch taken (R4)
    {1'b0, 4'd0,  1'b0, 6'd0},   // end code (R6)
    {1'b0, 4'd0,  1'b0, 6'd1},
    {1'b0, 4'd0,  1'b0, 6'd2},
    {1'b1, 4'd3,  1'b0, 6'd26},
    {1'b0, 4'd0,  1'b0, 6'd27},
    {1'b0, 4'd0,  1'b0, 6'd28},  // flag branch not taken (R5)
    {1'b0, 4'd0,  1'b0, 6'd0},
    {1'b0, 4'd0,  1'b0, 6'd1},
    {1'b0, 4'd0,  1'b0, 6'd2},
    {1'b1, 4'd5,  1'b0, 6'd30},
    {1'b0, 4'd0,  1'b0, 6'd63},
    {1'b0, 4'd0,  1'b0, 6'd0},   // wrap from 63 (R7)
    {1'b0, 4'd0,  1'b0, 6'd1},
    {1'b0, 4'd0,  1'b0, 6'd2},
    {1'b1, 4'd3,  1'b0, 6'd26},
    {1'b0, 4'd0,  1'b0, 6'd27},
    {1'b1, 4'd9,  1'b1, 6'd38},  // load beats taken branch (R8)
    {1'b1, 4'd12, 1'b0, 6'd44},  // load beats end code (R8)
    {1'b0, 4'd0,  1'b0, 6'd0},
    {1'b1, 4'd12, 1'b0, 6'd44},  // load beats sequential step (R8)
    {1'b0, 4'd0,  1'b0, 6'd0}
  };

  function automatic logic [23:0] tagOf(input logic [5:0] a);
    return {a, ~a, a ^ 6'h15, 6'h2A};
  endfunction

  function automatic logic [31:0] progWord(input logic [5:0] a);
    case (a)
      6'd0, 6'd1, 6'd26, 6'd63: return {2'b00, 6'd0,  tagOf(a)};
      6'd2:                     return {2'b01, 6'd2,  tagOf(a)};
      6'd27:                    return {2'b10, 6'd40, tagOf(a)};
      6'd30:                    return {2'b01, 6'd63, tagOf(a)};
      default:                  return {2'b11, 6'd0,  tagOf(a)};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic checkAt(input string req, input logic [5:0] pc);
    check(req, {26'd0, uPc}, {26'd0, pc});
    check(req, {31'd0, ctrlValid}, 32'd1);
    check({req, "_R3"}, {8'd0, ctrlOut}, {8'd0, tagOf(pc)});
  endtask

  initial begin
    #(CLK_NS * 100000);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step();
    // fill memory and map while reset is held
    for (int a = 0; a < 64; a++) begin
      cmWrEn = 1'b1; cmWrAddr = 6'(a); cmWrData = progWord(6'(a));
      step();
    end
    cmWrEn = 1'b0;
    for (int k = 0; k < 16; k++) begin
      mapWrEn = 1'b1; mapWrIdx = 4'(k); mapWrAddr = 6'(20 + 2 * k);
      step();
    end
    mapWrEn = 1'b0;
    // R9 reset state
    check("R9_pc", {26'd0, uPc}, 32'd0);
    check("R9_valid", {31'd0, ctrlValid}, 32'd0);
    check("R9_ctrl", {8'd0, ctrlOut}, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      opLoad = VEC[i][11]; opcode = VEC[i][10:7]; statusFlag = VEC[i][6];
      step();
      checkAt($sformatf("vec%0d", i), VEC[i][5:0]);
    end
    opLoad = 1'b0; statusFlag = 1'b0;

    // R2: remap opcode 7 to 50 during the run
    mapWrEn = 1'b1; mapWrIdx = 4'd7; mapWrAddr = 6'd50;
    step(); mapWrEn = 1'b0;
    checkAt("R2_pre1", 6'd1);
    step();
    checkAt("R2_pre2", 6'd2);
    opLoad = 1'b1; opcode = 4'd7;
    step(); opLoad = 1'b0;
    checkAt("R2_remap", 6'd50);
    step();
    checkAt("R6_after_remap", 6'd0);

    // R9: reset in the middle of a run
    step();
    checkAt("R9_prerst", 6'd1);
    rstN = 1'b0;
    #5;
    check("R9_midrst_pc", {26'd0, uPc}, 32'd0);
    check("R9_midrst_valid", {31'd0, ctrlValid}, 32'd0);
    check("R9_midrst_ctrl", {8'd0, ctrlOut}, 32'd0);
    step();
    rstN = 1'b1;
    step();
    checkAt("R9_restart", 6'd0);
    step();
    checkAt("R9_restart_next", 6'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule